// File: doc/BRIEF.md
# Interrupt Control and Priority Unit

This unit keeps one control byte for each of sixteen interrupt sources and picks the source the core should service next. Thirteen sources are internal: one converter-done event, two serial transmit events, two serial receive events, five timers of the first kind and three of the second kind. Each of them raises a one-cycle pulse on its own bit of `int_event`. The other three sources are external pins. Each pin passes through a two-flop synchronizer and is then detected by edge or by level, as its control byte selects.

Software reads and writes the control bytes over a plain byte-wide bus. A write takes effect at the clock edge where `bus_we` is high. A read is combinational from `bus_addr`. No part of the bus stalls, so there is no back-pressure.

The arbiter is combinational from the stored state. It reports the pending source with the highest priority. The acknowledge input `ack_valid`/`ack_idx` clears a serviced request. It is a plain control pulse that is always accepted, with no handshake. Masking against the processor's own priority level is done outside this unit.

Top module: `intr_prio_unit`

## Requirements
- R1: After reset every control byte reads 0x00, so every source has priority 0, no request, edge mode and polarity 0, and `irq_valid` is low with `irq_idx` and `irq_level` at 0.
- R2: The internal sources are at bus addresses 0x70 to 0x7C, with index = address − 0x70. Bits 2:0 hold the priority and bit 3 holds the request flag, which software can write to either value. Bits 7:4 are ignored on write and read as 0.
- R3: The external sources are at 0x7D, 0x7E and 0x7F (indexes 13 to 15). Bits 2:0 hold the priority, bit 3 the flag, bit 4 the polarity and bit 5 the mode (0 = edge, 1 = level). Bits 7:6 are ignored on write and read as 0.
- R4: An `int_event` pulse sets that source's flag at the next clock edge. If a bus write of flag 0 or an acknowledge reaches the same source in the same cycle, the set still wins.
- R5: In edge mode with polarity 0, a falling pin edge sets the flag. With polarity 1, a rising pin edge sets it. The edge of the wrong direction does nothing. After the pin changes, the flag reads 1 after the third rising clock edge, and not after the second.
- R6: In level mode the source's request is the synchronized pin: high for polarity 0, low for polarity 1. It is seen after the second rising clock edge following a pin change. The stored flag has no effect on arbitration, and pin edges do not set it.
- R7: `irq_valid` is high only when some source has a request and a nonzero priority. `irq_idx` and `irq_level` then give the source with the highest priority, and a tie goes to the lower index. When `irq_valid` is low, both read 0.
- R8: An `ack_valid` cycle clears the flag of source `ack_idx` if that source is internal or is in edge mode. An acknowledge to a source in level mode leaves its stored flag unchanged.
- R9: A bus write outside 0x70 to 0x7F changes no state, and a read there returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the control bytes |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| int_event | input | 13 | One-cycle request pulses from the internal sources |
| ext_pin | input | 3 | Asynchronous external interrupt pins |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 4 | Index of the source being acknowledged |
| irq_valid | output | 1 | A qualifying request exists |
| irq_idx | output | 4 | Index of the winning source |
| irq_level | output | 3 | Priority of the winning source |

## Verification
The hardest case to reach is an external source in level mode that holds a stored flag of 1 while its pin is inactive. The flag cannot be set from the pin in that mode, so the bench sets it with a direct bus write and then shows that arbitration ignores it and that an acknowledge leaves it in place. The synchronizer depth is checked by sampling the flag one clock before and one clock after it is due, with the pins driven on falling clock edges. Ties are built by giving two internal sources priority 7 and then clearing and disabling them one at a time.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int PRIO_W = 3;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              mode;   // 1 = level sensing (external only)
    logic              pol;    // sense polarity (external only)
    logic              flag;   // stored request
    logic [PRIO_W-1:0] prio;   // 0 = disabled
  } ctl_t;
endpackage

// File: rtl/intr_pin_sense.sv
module intr_pin_sense #(
  parameter int N_EXT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] pin,
  input  logic [N_EXT-1:0] pol,
  output logic [N_EXT-1:0] edge_hit,
  output logic [N_EXT-1:0] lvl_hit
);
  logic [N_EXT-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  for (genvar j = 0; j < N_EXT; j++) begin : g_pin
    // polarity 0: falling edge / high level; polarity 1: rising edge / low level
    assign edge_hit[j] = pol[j] ? (~last_q[j] & sync_q[j]) : (last_q[j] & ~sync_q[j]);
    assign lvl_hit[j]  = pol[j] ? ~sync_q[j] : sync_q[j];
  end
endmodule

// File: rtl/intr_ctl_bank.sv
module intr_ctl_bank
  import intr_pkg::*;
#(
  parameter int          N_INT     = 13,
  parameter int          N_EXT     = 3,
  parameter int          ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h70,
  localparam int         N_SRC     = N_INT + N_EXT,
  localparam int         IDX_W     = $clog2(N_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [N_INT-1:0]        int_event,
  input  logic [N_EXT-1:0]        ext_edge,
  input  logic [N_EXT-1:0]        ext_lvl,
  input  logic                    ack_valid,
  input  logic [IDX_W-1:0]        ack_idx,
  output logic [N_EXT-1:0]        ext_pol,
  output logic [N_SRC-1:0]        src_flag,
  output logic [N_SRC-1:0]        src_pend,
  output logic [N_SRC*PRIO_W-1:0] src_prio
);
  ctl_t ctl_q [N_SRC];
  ctl_t ctl_d [N_SRC];

  logic [ADDR_W-1:0] off;
  logic              in_rng;
  logic [IDX_W-1:0]  sel;

  assign off    = bus_addr - ADDR_W'(BASE_ADDR);
  assign in_rng = (bus_addr >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(N_SRC));
  assign sel    = off[IDX_W-1:0];

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic hit_wr, hit_ack, hw_set, is_lvl;

    if (i < N_INT) begin : g_int
      assign hw_set = int_event[i];
      assign is_lvl = 1'b0;
      assign src_pend[i] = ctl_q[i].flag;
    end else begin : g_ext
      assign is_lvl = ctl_q[i].mode;
      assign hw_set = ext_edge[i-N_INT] & ~ctl_q[i].mode;
      assign src_pend[i] = ctl_q[i].mode ? ext_lvl[i-N_INT] : ctl_q[i].flag;
      assign ext_pol[i-N_INT] = ctl_q[i].pol;
    end

    assign hit_wr  = bus_we && in_rng && (sel == IDX_W'(i));
    assign hit_ack = ack_valid && (ack_idx == IDX_W'(i)) && !is_lvl;

    always_comb begin
      ctl_d[i] = ctl_q[i];
      if (hit_wr) begin
        ctl_d[i].prio = bus_wdata[PRIO_W-1:0];
        ctl_d[i].flag = bus_wdata[3];
        if (i >= N_INT) begin
          ctl_d[i].pol  = bus_wdata[4];
          ctl_d[i].mode = bus_wdata[5];
        end
      end
      if (hit_ack) ctl_d[i].flag = 1'b0;
      if (hw_set)  ctl_d[i].flag = 1'b1;   // hardware set has the last word
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[i] <= '0;
      else        ctl_q[i] <= ctl_d[i];
    end

    assign src_flag[i] = ctl_q[i].flag;
    assign src_prio[i*PRIO_W +: PRIO_W] = ctl_q[i].prio;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (in_rng && sel == IDX_W'(i)) bus_rdata = DATA_W'(ctl_q[i]);
    end
  end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
#(
  parameter int  N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC*PRIO_W-1:0] prio,
  output logic                    valid,
  output logic [IDX_W-1:0]        idx,
  output logic [PRIO_W-1:0]       level
);
  always_comb begin
    idx   = '0;
    level = '0;
    // strict greater-than keeps the lowest index on a tie
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && prio[i*PRIO_W +: PRIO_W] > level) begin
        level = prio[i*PRIO_W +: PRIO_W];
        idx   = IDX_W'(i);
      end
    end
  end
  assign valid = (level != '0);
endmodule

// File: rtl/intr_prio_unit.sv
module intr_prio_unit
  import intr_pkg::*;
#(
  parameter int          N_INT     = 13,
  parameter int          N_EXT     = 3,
  parameter int          ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h70,
  localparam int         N_SRC     = N_INT + N_EXT,
  localparam int         IDX_W     = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_INT-1:0]  int_event,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_idx,
  output logic              irq_valid,
  output logic [IDX_W-1:0]  irq_idx,
  output logic [PRIO_W-1:0] irq_level
);
  logic [N_EXT-1:0]        ext_pol, ext_edge, ext_lvl;
  logic [N_SRC-1:0]        src_flag, src_pend;
  logic [N_SRC*PRIO_W-1:0] src_prio;

  intr_pin_sense #(.N_EXT(N_EXT)) u_sense (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .pol(ext_pol),
    .edge_hit(ext_edge), .lvl_hit(ext_lvl)
  );

  intr_ctl_bank #(
    .N_INT(N_INT), .N_EXT(N_EXT), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_event(int_event),
    .ext_edge(ext_edge), .ext_lvl(ext_lvl), .ack_valid(ack_valid),
    .ack_idx(ack_idx), .ext_pol(ext_pol), .src_flag(src_flag),
    .src_pend(src_pend), .src_prio(src_prio)
  );

  intr_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend(src_pend), .prio(src_prio),
    .valid(irq_valid), .idx(irq_idx), .level(irq_level)
  );
endmodule

// File: rtl/intr_prio_chk.sv
module intr_prio_chk
  import intr_pkg::*;
#(
  parameter int N_INT = 13,
  parameter int N_SRC = 16,
  parameter int IDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [N_INT-1:0]  int_event,
  input logic              ack_valid,
  input logic [IDX_W-1:0]  ack_idx,
  input logic              irq_valid,
  input logic [IDX_W-1:0]  irq_idx,
  input logic [PRIO_W-1:0] irq_level,
  input logic [N_SRC-1:0]  src_flag,
  input logic [N_SRC-1:0]  src_pend
);
  // R7: a valid winner always carries a nonzero level
  p_level_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_level != '0);

  // R7: outputs rest at zero without a winner
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_idx == '0 && irq_level == '0));

  // R7: the winner really has a request
  p_winner_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> src_pend[irq_idx]);

  for (genvar k = 0; k < N_INT; k++) begin : g_int_chk
    // R4: an event pulse always lands in the flag
    p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int_event[k] |=> src_flag[k]);

    // R8: an acknowledge clears an internal flag when nothing else touches it
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_idx == IDX_W'(k) && !int_event[k] && !bus_we) |=> !src_flag[k]);
  end
endmodule

bind intr_prio_unit intr_prio_chk #(.N_INT(N_INT), .N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .int_event(int_event),
  .ack_valid(ack_valid), .ack_idx(ack_idx), .irq_valid(irq_valid),
  .irq_idx(irq_idx), .irq_level(irq_level), .src_flag(src_flag),
  .src_pend(src_pend)
);

// File: tb/intr_prio_unit_bench.sv
module intr_prio_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [12:0] int_event = '0;
  logic [2:0]  ext_pin = '0;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_idx = '0;
  logic        irq_valid;
  logic [3:0]  irq_idx;
  logic [2:0]  irq_level;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intr_prio_unit u_intr_prio_unit (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_event(int_event),
    .ext_pin(ext_pin), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .irq_valid(irq_valid), .irq_idx(irq_idx), .irq_level(irq_level)
  );

  // {addr, wdata, exp_valid, exp_idx, exp_level}
  localparam logic [23:0] VEC [8] = '{
    {8'h70, 8'h0D, 1'b1, 4'd0,  3'd5},
    {8'h72, 8'h0F, 1'b1, 4'd2,  3'd7},
    {8'h75, 8'h0F, 1'b1, 4'd2,  3'd7},
    {8'h72, 8'h07, 1'b1, 4'd5,  3'd7},
    {8'h75, 8'h08, 1'b1, 4'd0,  3'd5},
    {8'h70, 8'h00, 1'b0, 4'd0,  3'd0},
    {8'h7C, 8'h09, 1'b1, 4'd12, 3'd1},
    {8'h7C, 8'hF1, 1'b0, 4'd0,  3'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic irq_chk(input string tag, input logic v, input logic [3:0] i, input logic [2:0] l);
    chk(tag, {24'd0, v, i, l}, {24'd0, v, i, l});
    chk(tag, {24'd0, irq_valid, irq_idx, irq_level}, {24'd0, v, i, l});
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 irq_valid", 32'(irq_valid), 0);
    chk("R1 irq_level", 32'(irq_level), 0);
    rd_chk("R1 read 0x70", 8'h70, 8'h00);
    rd_chk("R1 read 0x7F", 8'h7F, 8'h00);

    // table walk: R2 layout and R7 arbitration with ties and disabling
    for (int n = 0; n < 8; n++) begin
      wr(VEC[n][23:16], VEC[n][15:8]);
      chk("R7 valid", 32'(irq_valid), 32'(VEC[n][7]));
      chk("R7 idx",   32'(irq_idx),   32'(VEC[n][6:3]));
      chk("R7 level", 32'(irq_level), 32'(VEC[n][2:0]));
      rd_chk("R2 readback", VEC[n][23:16], VEC[n][15:8] & 8'h0F);
    end

    // R4: event pulse sets flag
    wr(8'h73, 8'h02);
    int_event[3] = 1'b1;
    @(negedge clk);
    int_event[3] = 1'b0;
    rd_chk("R4 event sets flag", 8'h73, 8'h0A);
    chk("R4 idx after event", 32'(irq_idx), 3);
    // R8: ack internal clears
    ack_idx = 4'd3; ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    rd_chk("R8 ack internal", 8'h73, 8'h02);
    // R4: set beats software clear in same cycle
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'h73; bus_wdata = 8'h02; int_event[3] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; int_event[3] = 1'b0;
    rd_chk("R4 set wins over write", 8'h73, 8'h0A);
    // R4: set beats ack in same cycle
    ack_idx = 4'd3; ack_valid = 1'b1; int_event[3] = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0; int_event[3] = 1'b0;
    rd_chk("R4 set wins over ack", 8'h73, 8'h0A);
    wr(8'h73, 8'h00);

    // R5: edge mode polarity 0 (falling)
    wr(8'h7D, 8'h03);
    rd_chk("R3 ext readback", 8'h7D, 8'h03);
    ext_pin[0] = 1'b1;
    cycles(4);
    rd_chk("R5 rising ignored pol0", 8'h7D, 8'h03);
    ext_pin[0] = 1'b0;
    cycles(2);
    rd_chk("R5 not yet after 2 edges", 8'h7D, 8'h03);
    cycles(1);
    rd_chk("R5 falling sets flag", 8'h7D, 8'h0B);
    irq_chk("R5 ext0 wins", 1'b1, 4'd13, 3'd3);
    ack_idx = 4'd13; ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    rd_chk("R8 ack edge ext", 8'h7D, 8'h03);
    chk("R8 valid after ack", 32'(irq_valid), 0);

    // R5: polarity 1 (rising)
    wr(8'h7E, 8'h14);
    ext_pin[1] = 1'b1;
    cycles(3);
    rd_chk("R5 rising sets pol1", 8'h7E, 8'h1C);
    irq_chk("R5 ext1 wins", 1'b1, 4'd14, 3'd4);
    wr(8'h7E, 8'hD4);
    rd_chk("R3 upper bits ignored", 8'h7E, 8'h14);

    // R6: level mode
    wr(8'h7F, 8'h26);
    chk("R6 inactive level", 32'(irq_valid), 0);
    ext_pin[2] = 1'b1;
    cycles(1);
    chk("R6 not yet after 1 edge", 32'(irq_valid), 0);
    cycles(1);
    irq_chk("R6 high level pol0", 1'b1, 4'd15, 3'd6);
    ext_pin[2] = 1'b0;
    cycles(2);
    chk("R6 level released", 32'(irq_valid), 0);
    rd_chk("R6 no flag from level pin", 8'h7F, 8'h26);
    wr(8'h7F, 8'h2E);
    chk("R6 stored flag ignored", 32'(irq_valid), 0);
    ack_idx = 4'd15; ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    rd_chk("R8 ack ignored in level mode", 8'h7F, 8'h2E);
    wr(8'h7F, 8'h3E);
    irq_chk("R6 low level pol1", 1'b1, 4'd15, 3'd6);
    wr(8'h7F, 8'h16);
    chk("R3 edge mode uses flag", 32'(irq_valid), 0);

    // R9: outside the window
    wr(8'h80, 8'hFF);
    wr(8'h6F, 8'hFF);
    rd_chk("R9 read 0x80", 8'h80, 8'h00);
    rd_chk("R9 read 0x6F", 8'h6F, 8'h00);
    chk("R9 no state change", 32'(irq_valid), 0);
    rd_chk("R9 neighbour intact", 8'h70, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule